// File: doc/BRIEF.md
# Sequential Integer Square Root Unit

This block computes the floor square root of an unsigned operand over several clock cycles, using shifts, one adder and one comparator, with no multiplier. A request is a one-cycle `start_i` pulse with the operand on `operand_i`. The unit then runs on its own and raises `done_o` for one cycle. In that cycle the root and the remainder (operand minus root squared) appear on the outputs. They stay there until the next completion.

Inside, a power-of-four probe starts one position below the top of the operand width. In the first phase it shifts right by two places per cycle while it is larger than the operand. In the second phase each cycle makes one trial. The sum of the partial result and the probe is compared with the working value. If the working value is not smaller, the sum is subtracted from it, and the partial result becomes itself shifted right by one plus the probe. Otherwise the partial result is only shifted right by one. The probe then moves down by two places. The work ends when the probe leaves its lowest position. Each probe position takes exactly one cycle in one of the two phases, and one extra cycle marks the change of phase. The latency is therefore the same for every operand.

A parameter chooses whether the remainder register is built. Without it, the remainder output is tied to zero.

Top module: `isqrt_seq`

## Requirements
- R1: During reset and in the first cycle after it, `busy_o` and `done_o` are 0, and `root_o` and `rem_o` are 0.
- R2: At completion, `root_o` is the largest integer r with r*r not greater than the operand that was accepted with the start.
- R3: At completion, `rem_o` (ROOT_W+1 bits, with REM_EN=1) equals the accepted operand minus `root_o` squared. It therefore never exceeds 2*`root_o`.
- R4: `done_o` is high for exactly one cycle. That cycle comes exactly ROOT_W+1 rising edges after the edge that accepted the start (9 edges for a 16-bit operand), whatever the operand value.
- R5: A start is accepted at a rising edge where `start_i` is 1 and `busy_o` is 0. `busy_o` is 1 from the next cycle until completion, and it is 0 in the `done_o` cycle.
- R6: While `busy_o` is 1, `start_i` and `operand_i` have no effect. The running result is unchanged, and no second completion follows.
- R7: `root_o` and `rem_o` keep their values in every cycle where `done_o` is 0.
- R8: A zero operand gives root 0 and remainder 0 with the same latency as any other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled when not busy |
| operand_i | input | OP_W | Unsigned value to take the root of |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| root_o | output | ROOT_W | Floor square root (OP_W/2 bits) |
| rem_o | output | ROOT_W+1 | Operand minus root squared, or zero when REM_EN=0 |

## Verification
The hardest cases to reach from the ports are the edges of the probe search. Operands of zero and one make the probe shift all the way to its last position or to zero. Values just below and just above a power of four stop the skip phase one position apart. Values just below a perfect square give the largest remainder. The stimulus drives each of these directly, together with the largest operand. It then adds a seeded random mix in which some runs have start pulses and a changed operand injected in the middle of the run, to show they are ignored.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SKIP = 2'd1,
      ST_STEP = 2'd2
   } isqrt_state_e;

endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
   import isqrt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic probe_gt,
   input  logic probe_zero,
   input  logic probe_last,
   output logic load,
   output logic skip_shift,
   output logic step_en,
   output logic finish,
   output logic busy
);

   isqrt_state_e state_q, state_d;

   always_comb begin
      state_d    = state_q;
      load       = 1'b0;
      skip_shift = 1'b0;
      step_en    = 1'b0;
      finish     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load    = 1'b1;
               state_d = ST_SKIP;
            end
         end
         ST_SKIP: begin
            if (probe_gt) begin
               skip_shift = 1'b1;
            end else if (probe_zero) begin
               finish  = 1'b1;
               state_d = ST_IDLE;
            end else begin
               state_d = ST_STEP;
            end
         end
         ST_STEP: begin
            step_en = 1'b1;
            if (probe_last) begin
               finish  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath #(
   parameter int OP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            skip_shift,
   input  logic            step_en,
   input  logic [OP_W-1:0] operand,
   output logic            probe_gt,
   output logic            probe_zero,
   output logic            probe_last,
   output logic [OP_W-1:0] work_d,
   output logic [OP_W-1:0] res_d
);

   localparam int SUM_W = OP_W + 1;
   localparam logic [OP_W-1:0] PROBE_INIT = OP_W'(1) << (OP_W - 2);

   logic [OP_W-1:0]  work_q, res_q, probe_q, probe_d;
   logic [SUM_W-1:0] trial;
   logic             fits;

   assign trial      = {1'b0, res_q} + {1'b0, probe_q};
   assign fits       = ({1'b0, work_q} >= trial);
   assign probe_gt   = (probe_q > work_q);
   assign probe_zero = (probe_q == '0);
   assign probe_last = ((probe_q >> 2) == '0);

   always_comb begin
      work_d  = work_q;
      res_d   = res_q;
      probe_d = probe_q;
      if (load) begin
         work_d  = operand;
         res_d   = '0;
         probe_d = PROBE_INIT;
      end else if (skip_shift) begin
         probe_d = probe_q >> 2;
      end else if (step_en) begin
         probe_d = probe_q >> 2;
         if (fits) begin
            work_d = work_q - trial[OP_W-1:0];
            res_d  = (res_q >> 1) + probe_q;
         end else begin
            res_d  = res_q >> 1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q  <= '0;
         res_q   <= '0;
         probe_q <= '0;
      end else begin
         work_q  <= work_d;
         res_q   <= res_d;
         probe_q <= probe_d;
      end
   end

   logic unused_trial_top;
   assign unused_trial_top = trial[OP_W];

endmodule

// File: rtl/isqrt_result.sv
module isqrt_result #(
   parameter int OP_W   = 16,
   parameter bit REM_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 finish,
   input  logic [OP_W-1:0]      res_d,
   input  logic [OP_W-1:0]      work_d,
   output logic                 done,
   output logic [OP_W/2-1:0]    root,
   output logic [OP_W/2:0]      rem
);

   localparam int ROOT_W = OP_W / 2;
   localparam int REM_W  = ROOT_W + 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         root <= '0;
      end else begin
         done <= finish;
         if (finish) root <= res_d[ROOT_W-1:0];
      end
   end

   generate
      if (REM_EN) begin : g_rem
         logic [REM_W-1:0] rem_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rem_q <= '0;
            else if (finish) rem_q <= work_d[REM_W-1:0];
         end
         assign rem = rem_q;
         logic unused_work_hi;
         assign unused_work_hi = ^work_d[OP_W-1:REM_W];
      end else begin : g_no_rem
         assign rem = '0;
         logic unused_work;
         assign unused_work = ^work_d;
      end
   endgenerate

   logic unused_res_hi;
   assign unused_res_hi = ^res_d[OP_W-1:ROOT_W];

endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
   parameter int OP_W   = 16,
   parameter bit REM_EN = 1'b1,
   localparam int ROOT_W = OP_W / 2,
   localparam int REM_W  = ROOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OP_W-1:0]   operand_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ROOT_W-1:0] root_o,
   output logic [REM_W-1:0]  rem_o
);

   generate
      if ((OP_W % 2) != 0 || OP_W < 4) begin : g_bad_width
         $error("isqrt_seq: OP_W must be even and at least 4");
      end
   endgenerate

   logic            load, skip_shift, step_en, finish;
   logic            probe_gt, probe_zero, probe_last;
   logic [OP_W-1:0] work_d, res_d;

   isqrt_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .probe_gt   (probe_gt),
      .probe_zero (probe_zero),
      .probe_last (probe_last),
      .load       (load),
      .skip_shift (skip_shift),
      .step_en    (step_en),
      .finish     (finish),
      .busy       (busy_o)
   );

   isqrt_datapath #(.OP_W(OP_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .skip_shift (skip_shift),
      .step_en    (step_en),
      .operand    (operand_i),
      .probe_gt   (probe_gt),
      .probe_zero (probe_zero),
      .probe_last (probe_last),
      .work_d     (work_d),
      .res_d      (res_d)
   );

   isqrt_result #(.OP_W(OP_W), .REM_EN(REM_EN)) u_res (
      .clk    (clk),
      .rst_n  (rst_n),
      .finish (finish),
      .res_d  (res_d),
      .work_d (work_d),
      .done   (done_o),
      .root   (root_o),
      .rem    (rem_o)
   );

endmodule

// File: rtl/isqrt_seq_chk.sv
module isqrt_seq_chk #(
   parameter int OP_W   = 16,
   parameter bit REM_EN = 1'b1,
   localparam int ROOT_W = OP_W / 2,
   localparam int REM_W  = ROOT_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [OP_W-1:0]   operand_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [ROOT_W-1:0] root_o,
   input logic [REM_W-1:0]  rem_o
);

   logic [OP_W-1:0] cap_op;
   logic [7:0]      since_start;
   logic            accept;
   logic [OP_W+1:0] root_sq, rebuilt, root_ext;

   assign accept   = start_i && !busy_o;
   assign root_ext = (OP_W + 2)'(root_o);
   assign root_sq  = root_ext * root_ext;
   assign rebuilt  = root_sq + (OP_W + 2)'(rem_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_op      <= '0;
         since_start <= '0;
      end else if (accept) begin
         cap_op      <= operand_i;
         since_start <= '0;
      end else if (busy_o) begin
         since_start <= since_start + 8'd1;
      end
   end

   // R4
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (since_start == 8'(ROOT_W + 1)));
   // R5
   a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o);
   a_r5_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   // R2 and R3
   a_r2_root_floor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (root_sq <= (OP_W + 2)'(cap_op)) &&
                 ((root_ext + 1) * (root_ext + 1) > (OP_W + 2)'(cap_op)));
   generate
      if (REM_EN) begin : g_rem_chk
         a_r3_rem_exact: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (rebuilt == (OP_W + 2)'(cap_op)));
      end
   endgenerate
   // R7
   a_r7_hold_root: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(root_o));
   a_r7_hold_rem: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rem_o));

endmodule

bind isqrt_seq isqrt_seq_chk #(.OP_W(OP_W), .REM_EN(REM_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .operand_i (operand_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .root_o    (root_o),
   .rem_o     (rem_o)
);

// File: tb/tb_isqrt_seq.sv
module tb_isqrt_seq;

   localparam int OP_W   = 16;
   localparam int ROOT_W = OP_W / 2;
   localparam int REM_W  = ROOT_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [OP_W-1:0]   operand_i = '0;
   logic              busy_o, done_o;
   logic [ROOT_W-1:0] root_o;
   logic [REM_W-1:0]  rem_o;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   isqrt_seq #(.OP_W(OP_W), .REM_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
      .busy_o(busy_o), .done_o(done_o), .root_o(root_o), .rem_o(rem_o)
   );

   function automatic int exp_root(int v);
      int r = 0;
      while ((r + 1) * (r + 1) <= v) r++;
      return r;
   endfunction

   task automatic check(string req, int actual, int expected, string what);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   // One request; inject = drive ignored starts and operand changes mid-run (R6)
   task automatic run(int op, bit inject);
      int er = exp_root(op);
      int em = op - er * er;
      @(negedge clk);
      start_i = 1'b1; operand_i = OP_W'(op);
      @(negedge clk);
      start_i = 1'b0;
      check("R5", int'(busy_o), 1, "busy after accept");
      for (int k = 1; k <= ROOT_W + 1; k++) begin
         if (inject && (k == 2 || k == 5)) begin
            start_i = 1'b1; operand_i = OP_W'(op ^ 16'h5a5a);
         end
         @(negedge clk);
         start_i = 1'b0;
         if (k <= ROOT_W) begin
            if (done_o !== 1'b0 || busy_o !== 1'b1) begin
               check("R4", int'(done_o), 0, "early done");
               check("R5", int'(busy_o), 1, "busy during run");
            end
         end
      end
      check("R4", int'(done_o), 1, "done at fixed latency");
      check("R5", int'(busy_o), 0, "busy low in done cycle");
      check(op == 0 ? "R8" : "R2", int'(root_o), er, $sformatf("root of %0d", op));
      check(op == 0 ? "R8" : "R3", int'(rem_o), em, $sformatf("remainder of %0d", op));
      @(negedge clk);
      check("R4", int'(done_o), 0, "done one cycle");
      check("R7", int'(root_o), er, "root held");
      check("R7", int'(rem_o), em, "remainder held");
      if (inject) check("R6", int'(busy_o), 0, "no second run after ignored start");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      int seed_dummy;
      seed_dummy = $urandom(32'd2718);
      #5;
      check("R1", int'(busy_o), 0, "busy in reset");
      check("R1", int'(done_o), 0, "done in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(busy_o), 0, "busy after reset");
      check("R1", int'(done_o), 0, "done after reset");
      check("R1", int'(root_o), 0, "root after reset");
      check("R1", int'(rem_o), 0, "rem after reset");
      // directed corners: zero, one, powers of four and neighbours, squares, max
      run(0, 1'b0);
      run(1, 1'b0);
      run(2, 1'b0);
      run(3, 1'b0);
      run(4, 1'b0);
      run(15, 1'b0);
      run(16383, 1'b0);
      run(16384, 1'b0);
      run(65024, 1'b0);
      run(65025, 1'b0);
      run(65535, 1'b0);
      run(0, 1'b1);
      run(48399, 1'b1);
      for (int i = 0; i < 300; i++) begin
         int v = int'($urandom() & 32'hffff);
         if ((i % 5) == 0) v = v >> ($urandom() % 16);
         run(v, (i % 3) == 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule